// File: doc/BRIEF.md
# Packed SIMD Integer ALU

A purely combinational integer ALU for a 32-bit datapath. Each evaluation takes a 5-bit micro-op, two 32-bit operands and a 3-bit pack select, and produces one 32-bit result in the same cycle. The micro-op is a 2-bit class (arithmetic, bitwise, compare, shift) followed by a 3-bit operation code inside that class.

Addition, subtraction, logical shifts and right rotation can also run lane by lane. The word is then split into independent lanes of 16, 8, 4 or 2 bits. No carry, borrow or shifted-out bit crosses a lane boundary. All other operations ignore the pack select and always work on the full word. The block is placed after operand selection. Immediates, register reads and the choice of opr_a and opr_b are made upstream. Load-upper and load-immediate forms are issued as OR with opr_a driven to zero.

Top module: `simd_alu`

## Requirements
- R1: The micro-op is {class[1:0], op[2:0]}. Class 00 with op 001 returns opr_a + opr_b modulo 2^32, and class 00 with op 000 returns opr_a - opr_b modulo 2^32.
- R2: Pack select codes are 000 = 32-bit, 001 = 16-bit lanes, 010 = 8-bit lanes, 011 = 4-bit lanes and 100 = 2-bit lanes. For add and subtract, lane i of the result is computed from lane i of each operand only, and the carry or borrow out of each lane is dropped.
- R3: Class 01 is bitwise: op 001 returns AND, op 010 returns OR and op 100 returns XOR of the two operands.
- R4: An OR (class 01, op 010) with opr_a equal to zero returns opr_b unchanged.
- R5: Class 10 is compare: op 001 is signed less-than and op 010 is unsigned less-than. The result is 1 when opr_a < opr_b and 0 otherwise, placed in bit 0 with bits 31:1 zero.
- R6: Class 11 is shift with the amount in opr_b[4:0]. Op 001 is arithmetic right (sign fill), op 010 is logical right (zero fill) and op 100 is logical left (zero fill).
- R7: Class 11, op 110 rotates opr_a right by opr_b[4:0]. Bits leaving bit 0 re-enter at bit 31.
- R8: In a packed mode, logical right, left and rotate right act on each lane separately. Every lane uses the same amount, taken from opr_b modulo the lane width, which means the low log2(lane width) bits of opr_b.
- R9: Bitwise, compare and arithmetic right shift ignore the pack select and always give the full 32-bit result.
- R10: Any micro-op not listed in R1, R3, R5, R6 and R7 returns zero.
- R11: Pack select codes 101, 110 and 111 make lane-capable operations behave as in 32-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uop_i | input | 5 | Micro-op: class in bits 4:3, operation in bits 2:0 |
| pack_i | input | 3 | Lane width select for add, subtract, logical shifts and rotate |
| opr_a_i | input | 32 | First operand; the value shifted or rotated |
| opr_b_i | input | 32 | Second operand; the shift or rotate amount for class 11 |
| result_o | output | 32 | Combinational result |

## Verification
The bench targets lane boundaries. Carries out of the top of a lane (0xFF+0x01 in byte mode) must vanish, or the neighbouring lane comes out one too high. Shift amounts equal to or above the lane width must wrap modulo the width, or lanes would be cleared or bits would bleed across. Rotate by zero and by every amount up to 31 is swept at each width, because an error at amount zero shows up as the whole lane being ORed with itself or cleared. Reserved pack codes, the ignored pack select on AND and arithmetic right shift, signed versus unsigned compare on a negative operand, and undefined micro-ops are each probed. A design that decoded them wrongly would produce a lane-split result or a stray non-zero value.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int UOP_W = 5;

    // Class field, uop[4:3]
    typedef enum logic [1:0] {
        CLS_ARITH = 2'b00,
        CLS_LOGIC = 2'b01,
        CLS_CMP   = 2'b10,
        CLS_SHIFT = 2'b11
    } alu_cls_e;

    // Operation field, uop[2:0], per class
    localparam logic [2:0] OP_SUB  = 3'b000;
    localparam logic [2:0] OP_ADD  = 3'b001;
    localparam logic [2:0] OP_AND  = 3'b001;
    localparam logic [2:0] OP_OR   = 3'b010;
    localparam logic [2:0] OP_XOR  = 3'b100;
    localparam logic [2:0] OP_SLT  = 3'b001;
    localparam logic [2:0] OP_SLTU = 3'b010;
    localparam logic [2:0] OP_SRA  = 3'b001;
    localparam logic [2:0] OP_SRL  = 3'b010;
    localparam logic [2:0] OP_SLL  = 3'b100;
    localparam logic [2:0] OP_ROR  = 3'b110;

    // Decoded function
    typedef enum logic [3:0] {
        FN_NONE,
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_SLT,
        FN_SLTU,
        FN_SRA,
        FN_SRL,
        FN_SLL,
        FN_ROR
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_SRL,
        SH_SLL,
        SH_ROR,
        SH_SRA
    } shift_mode_e;

endpackage

// File: rtl/simd_alu_decode.sv
module simd_alu_decode
    import simd_alu_pkg::*;
#(
    parameter int PACK_W      = 3,
    parameter int PACK_LEVELS = 5,
    parameter int IDX_W       = $clog2(PACK_LEVELS)
) (
    input  logic [UOP_W-1:0]  uop_i,
    input  logic [PACK_W-1:0] pack_i,
    output alu_fn_e           fn_o,
    output logic [IDX_W-1:0]  idx_o
);

    alu_cls_e   cls;
    logic [2:0] op;
    logic       lane_capable;

    assign cls = alu_cls_e'(uop_i[4:3]);
    assign op  = uop_i[2:0];

    always_comb begin
        fn_o = FN_NONE;
        unique case (cls)
            CLS_ARITH: begin
                case (op)
                    OP_ADD:  fn_o = FN_ADD;
                    OP_SUB:  fn_o = FN_SUB;
                    default: fn_o = FN_NONE;
                endcase
            end
            CLS_LOGIC: begin
                case (op)
                    OP_AND:  fn_o = FN_AND;
                    OP_OR:   fn_o = FN_OR;
                    OP_XOR:  fn_o = FN_XOR;
                    default: fn_o = FN_NONE;
                endcase
            end
            CLS_CMP: begin
                case (op)
                    OP_SLT:  fn_o = FN_SLT;
                    OP_SLTU: fn_o = FN_SLTU;
                    default: fn_o = FN_NONE;
                endcase
            end
            CLS_SHIFT: begin
                case (op)
                    OP_SRA:  fn_o = FN_SRA;
                    OP_SRL:  fn_o = FN_SRL;
                    OP_SLL:  fn_o = FN_SLL;
                    OP_ROR:  fn_o = FN_ROR;
                    default: fn_o = FN_NONE;
                endcase
            end
        endcase
    end

    // Only add, sub, srl, sll and ror may split into lanes
    assign lane_capable = (fn_o == FN_ADD) || (fn_o == FN_SUB) ||
                          (fn_o == FN_SRL) || (fn_o == FN_SLL) ||
                          (fn_o == FN_ROR);

    always_comb begin
        if (lane_capable && (int'(pack_i) < PACK_LEVELS))
            idx_o = pack_i[IDX_W-1:0];
        else
            idx_o = '0;
    end

endmodule

// File: rtl/simd_alu_addsub.sv
module simd_alu_addsub #(
    parameter int DATA_W      = 32,
    parameter int PACK_LEVELS = 5,
    parameter int IDX_W       = $clog2(PACK_LEVELS)
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] sum_o
);

    logic [DATA_W-1:0] per_w [PACK_LEVELS];

    // One independent adder set per lane width; carries never leave a lane
    for (genvar k = 0; k < PACK_LEVELS; k++) begin : g_w
        localparam int W = DATA_W >> k;
        localparam int L = DATA_W / W;
        logic [DATA_W-1:0] res;
        for (genvar l = 0; l < L; l++) begin : g_l
            logic [W-1:0] xa;
            logic [W-1:0] xb;
            assign xa = a_i[l*W +: W];
            assign xb = sub_i ? ~b_i[l*W +: W] : b_i[l*W +: W];
            assign res[l*W +: W] = xa + xb + {{(W-1){1'b0}}, sub_i};
        end
        assign per_w[k] = res;
    end

    always_comb begin
        if (int'(idx_i) < PACK_LEVELS)
            sum_o = per_w[idx_i];
        else
            sum_o = per_w[0];
    end

endmodule

// File: rtl/simd_alu_shift.sv
module simd_alu_shift
    import simd_alu_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PACK_LEVELS = 5,
    parameter int IDX_W       = $clog2(PACK_LEVELS),
    parameter int SHAMT_W     = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  shift_mode_e        mode_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [DATA_W-1:0]  res_o
);

    logic [DATA_W-1:0] per_w [PACK_LEVELS];
    logic [DATA_W-1:0] sra_res;

    // Arithmetic right shift exists only at full width
    assign sra_res = DATA_W'($signed(a_i) >>> amt_i);

    for (genvar k = 0; k < PACK_LEVELS; k++) begin : g_w
        localparam int W  = DATA_W >> k;
        localparam int L  = DATA_W / W;
        localparam int SW = $clog2(W);
        logic [SW-1:0]     amt;
        logic [DATA_W-1:0] res;
        // Amount modulo lane width: the low SW bits
        assign amt = amt_i[SW-1:0];
        for (genvar l = 0; l < L; l++) begin : g_l
            logic [W-1:0] lane;
            logic [W-1:0] rot;
            assign lane = a_i[l*W +: W];
            assign rot  = (lane >> amt) | (lane << (W - int'(amt)));
            assign res[l*W +: W] = (mode_i == SH_SLL) ? (lane << amt) :
                                   (mode_i == SH_ROR) ? rot :
                                                        (lane >> amt);
        end
        assign per_w[k] = res;
    end

    always_comb begin
        if (mode_i == SH_SRA)
            res_o = sra_res;
        else if (int'(idx_i) < PACK_LEVELS)
            res_o = per_w[idx_i];
        else
            res_o = per_w[0];
    end

endmodule

// File: rtl/simd_alu_logic.sv
module simd_alu_logic
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_fn_e           fn_i,
    output logic [DATA_W-1:0] res_o
);

    logic lt_s;
    logic lt_u;

    assign lt_s = $signed(a_i) < $signed(b_i);
    assign lt_u = a_i < b_i;

    always_comb begin
        unique case (fn_i)
            FN_AND:  res_o = a_i & b_i;
            FN_OR:   res_o = a_i | b_i;
            FN_XOR:  res_o = a_i ^ b_i;
            FN_SLT:  res_o = {{(DATA_W-1){1'b0}}, lt_s};
            FN_SLTU: res_o = {{(DATA_W-1){1'b0}}, lt_u};
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PACK_W      = 3,
    parameter int PACK_LEVELS = 5
) (
    input  logic [UOP_W-1:0]  uop_i,
    input  logic [PACK_W-1:0] pack_i,
    input  logic [DATA_W-1:0] opr_a_i,
    input  logic [DATA_W-1:0] opr_b_i,
    output logic [DATA_W-1:0] result_o
);

    localparam int IDX_W   = $clog2(PACK_LEVELS);
    localparam int SHAMT_W = $clog2(DATA_W);

    alu_fn_e           fn;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] addsub_res;
    logic [DATA_W-1:0] shift_res;
    logic [DATA_W-1:0] logic_res;
    shift_mode_e       sh_mode;

    simd_alu_decode #(
        .PACK_W      (PACK_W),
        .PACK_LEVELS (PACK_LEVELS),
        .IDX_W       (IDX_W)
    ) u_decode (
        .uop_i  (uop_i),
        .pack_i (pack_i),
        .fn_o   (fn),
        .idx_o  (idx)
    );

    simd_alu_addsub #(
        .DATA_W      (DATA_W),
        .PACK_LEVELS (PACK_LEVELS),
        .IDX_W       (IDX_W)
    ) u_addsub (
        .a_i   (opr_a_i),
        .b_i   (opr_b_i),
        .sub_i (fn == FN_SUB),
        .idx_i (idx),
        .sum_o (addsub_res)
    );

    always_comb begin
        unique case (fn)
            FN_SLL:  sh_mode = SH_SLL;
            FN_ROR:  sh_mode = SH_ROR;
            FN_SRA:  sh_mode = SH_SRA;
            default: sh_mode = SH_SRL;
        endcase
    end

    simd_alu_shift #(
        .DATA_W      (DATA_W),
        .PACK_LEVELS (PACK_LEVELS),
        .IDX_W       (IDX_W),
        .SHAMT_W     (SHAMT_W)
    ) u_shift (
        .a_i    (opr_a_i),
        .amt_i  (opr_b_i[SHAMT_W-1:0]),
        .mode_i (sh_mode),
        .idx_i  (idx),
        .res_o  (shift_res)
    );

    simd_alu_logic #(
        .DATA_W (DATA_W)
    ) u_logic (
        .a_i   (opr_a_i),
        .b_i   (opr_b_i),
        .fn_i  (fn),
        .res_o (logic_res)
    );

    // Output selection
    always_comb begin
        unique case (fn)
            FN_ADD, FN_SUB:                          result_o = addsub_res;
            FN_AND, FN_OR, FN_XOR, FN_SLT, FN_SLTU:  result_o = logic_res;
            FN_SRA, FN_SRL, FN_SLL, FN_ROR:          result_o = shift_res;
            default:                                 result_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk (
    input logic [4:0]  uop_i,
    input logic [31:0] opr_a_i,
    input logic [31:0] opr_b_i,
    input logic [31:0] result_o
);

    logic known;

    assign known = (uop_i == 5'h00) || (uop_i == 5'h01) || (uop_i == 5'h09) ||
                   (uop_i == 5'h0A) || (uop_i == 5'h0C) || (uop_i == 5'h11) ||
                   (uop_i == 5'h12) || (uop_i == 5'h19) || (uop_i == 5'h1A) ||
                   (uop_i == 5'h1C) || (uop_i == 5'h1E);

    always_comb begin
        // Lane sums keep bit 0 as the XOR of the operand bits at any width
        if (uop_i == 5'h01 || uop_i == 5'h00) begin
            p_add_lsb_r1: assert (result_o[0] == (opr_a_i[0] ^ opr_b_i[0]))
                else $error("add/sub bit 0 wrong");
        end
        if (uop_i == 5'h09) begin
            p_and_subset_r3: assert (((result_o & ~opr_a_i) | (result_o & ~opr_b_i)) == 32'h0)
                else $error("AND result has bits outside operands");
        end
        if (uop_i == 5'h0A) begin
            p_or_superset_r3: assert ((result_o & opr_a_i) == opr_a_i)
                else $error("OR result lost opr_a bits");
        end
        if (uop_i == 5'h0A && opr_a_i == 32'h0) begin
            p_lui_pass_r4: assert (result_o == opr_b_i)
                else $error("OR with zero opr_a altered opr_b");
        end
        if (uop_i == 5'h11 || uop_i == 5'h12) begin
            p_cmp_zext_r5: assert (result_o[31:1] == 31'h0)
                else $error("compare result not zero-extended");
        end
        if (uop_i == 5'h1E) begin
            p_ror_ones_r7: assert ($countones(result_o) == $countones(opr_a_i))
                else $error("rotate changed population count");
        end
        if (!known) begin
            p_undef_zero_r10: assert (result_o == 32'h0)
                else $error("undefined micro-op gave non-zero result");
        end
    end

endmodule

bind simd_alu simd_alu_chk u_chk (
    .uop_i    (uop_i),
    .opr_a_i  (opr_a_i),
    .opr_b_i  (opr_b_i),
    .result_o (result_o)
);

// File: tb/tb_simd_alu.sv
module tb_simd_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk;
    logic        rst_n;
    logic [4:0]  uop;
    logic [2:0]  pack;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [31:0] res;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    simd_alu dut (
        .uop_i    (uop),
        .pack_i   (pack),
        .opr_a_i  (opa),
        .opr_b_i  (opb),
        .result_o (res)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [4:0]  u;
        logic [2:0]  p;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{5'h01, 3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 8'd1},  // R1 add
        '{5'h00, 3'd0, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 8'd1},  // R1 sub
        '{5'h00, 3'd0, 32'h00000005, 32'h00010007, 32'hFFFEFFFE, 8'd1},  // R1 sub full word
        '{5'h01, 3'd2, 32'hFF017F80, 32'h01010180, 32'h00028000, 8'd2},  // R2 byte add
        '{5'h00, 3'd1, 32'h00000005, 32'h00010007, 32'hFFFFFFFE, 8'd2},  // R2 halfword sub
        '{5'h01, 3'd4, 32'hFFFFFFFF, 32'h55555555, 32'h00000000, 8'd2},  // R2 2-bit add
        '{5'h09, 3'd0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 8'd3},  // R3 and
        '{5'h0A, 3'd0, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 8'd3},  // R3 or
        '{5'h0C, 3'd0, 32'hAAAA5555, 32'hFFFF0000, 32'h55555555, 8'd3},  // R3 xor
        '{5'h0A, 3'd0, 32'h00000000, 32'h12345000, 32'h12345000, 8'd4},  // R4 load-upper form
        '{5'h11, 3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 8'd5},  // R5 signed
        '{5'h12, 3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 8'd5},  // R5 unsigned
        '{5'h19, 3'd0, 32'h80000010, 32'h00000004, 32'hF8000001, 8'd6},  // R6 sra
        '{5'h1A, 3'd0, 32'h80000010, 32'h00000004, 32'h08000001, 8'd6},  // R6 srl
        '{5'h1C, 3'd0, 32'h80000001, 32'h00000021, 32'h00000002, 8'd6},  // R6 sll, amt bits 4:0
        '{5'h1E, 3'd0, 32'h00000001, 32'h00000001, 32'h80000000, 8'd7},  // R7 ror
        '{5'h1C, 3'd3, 32'h11111111, 32'h00000007, 32'h88888888, 8'd8},  // R8 nibble sll, 7 mod 4
        '{5'h1A, 3'd4, 32'hFFFFFFFF, 32'h00000003, 32'h55555555, 8'd8},  // R8 2-bit srl, 3 mod 2
        '{5'h1E, 3'd1, 32'h00018000, 32'h00000001, 32'h80004000, 8'd8},  // R8 halfword ror
        '{5'h09, 3'd2, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 8'd9},  // R9 and ignores pack
        '{5'h19, 3'd1, 32'h80000010, 32'h00000004, 32'hF8000001, 8'd9}   // R9 sra ignores pack
    };

    localparam logic [4:0] UOPS [12] = '{
        5'h01, 5'h00, 5'h09, 5'h0A, 5'h0C, 5'h11,
        5'h12, 5'h19, 5'h1A, 5'h1C, 5'h1E, 5'h07
    };

    // Behavioural model written from the requirements
    function automatic logic [31:0] ref_alu(input logic [4:0] u, input logic [2:0] p,
                                            input logic [31:0] a, input logic [31:0] b);
        int w;
        logic [31:0] r;
        bit lane_op;
        lane_op = (u == 5'h01) || (u == 5'h00) || (u == 5'h1A) || (u == 5'h1C) || (u == 5'h1E);
        case (p)
            3'd1:    w = 16;
            3'd2:    w = 8;
            3'd3:    w = 4;
            3'd4:    w = 2;
            default: w = 32;
        endcase
        r = 32'h0;
        if (lane_op) begin
            for (int l = 0; l < 32 / w; l++) begin
                logic [63:0] mask, la, lb, v;
                int s;
                mask = (64'd1 << w) - 64'd1;
                la   = ({32'h0, a} >> (l * w)) & mask;
                lb   = ({32'h0, b} >> (l * w)) & mask;
                s    = int'(b % w);
                case (u)
                    5'h01:   v = la + lb;
                    5'h00:   v = la - lb;
                    5'h1A:   v = la >> s;
                    5'h1C:   v = la << s;
                    default: v = (la >> s) | (la << (w - s));
                endcase
                r = r | 32'((v & mask) << (l * w));
            end
        end else begin
            case (u)
                5'h09:   r = a & b;
                5'h0A:   r = a | b;
                5'h0C:   r = a ^ b;
                5'h11:   r = {31'h0, $signed(a) < $signed(b)};
                5'h12:   r = {31'h0, a < b};
                5'h19:   r = 32'($signed(a) >>> b[4:0]);
                default: r = 32'h0;
            endcase
        end
        return r;
    endfunction

    function automatic int req_of(input logic [4:0] u, input logic [2:0] p);
        bit packed_mode;
        packed_mode = (p >= 3'd1) && (p <= 3'd4);
        case (u)
            5'h01, 5'h00:        return (p > 3'd4) ? 11 : (packed_mode ? 2 : 1);
            5'h09, 5'h0A, 5'h0C: return packed_mode ? 9 : 3;
            5'h11, 5'h12:        return packed_mode ? 9 : 5;
            5'h19:               return packed_mode ? 9 : 6;
            5'h1A, 5'h1C:        return (p > 3'd4) ? 11 : (packed_mode ? 8 : 6);
            5'h1E:               return (p > 3'd4) ? 11 : (packed_mode ? 8 : 7);
            default:             return 10;
        endcase
    endfunction

    task automatic apply(input logic [4:0] u, input logic [2:0] p,
                         input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        uop  <= u;
        pack <= p;
        opa  <= a;
        opb  <= b;
        @(negedge clk);
    endtask

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input int req,
                         input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: uop=%h pack=%0d a=%h b=%h got %h expected %h",
                     req, what, uop, pack, opa, opb, got, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        uop   = 5'h00;
        pack  = 3'd0;
        opa   = 32'h0;
        opb   = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res, 32'h0, 1, "idle inputs during reset, R1 0-0");
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].u, VECS[i].p, VECS[i].a, VECS[i].b);
            check(res, VECS[i].e, int'(VECS[i].req), "table vector");
        end

        // R10: undefined micro-ops return zero
        apply(5'h07, 3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check(res, 32'h0, 10, "undefined arith op");
        apply(5'h1F, 3'd2, 32'h12345678, 32'h00000003);
        check(res, 32'h0, 10, "undefined shift op");
        apply(5'h08, 3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check(res, 32'h0, 10, "undefined logic op");

        // R11: reserved pack codes act as full width
        apply(5'h01, 3'd5, 32'h0000FFFF, 32'h00000001);
        check(res, 32'h00010000, 11, "reserved pack 101 add");
        apply(5'h1E, 3'd7, 32'h00000001, 32'h00000001);
        check(res, 32'h80000000, 11, "reserved pack 111 ror");

        // R8: every shift amount at every width for srl, sll, ror
        for (int pk = 0; pk < 5; pk++) begin
            for (int amt = 0; amt < 32; amt++) begin
                for (int m = 0; m < 3; m++) begin
                    logic [4:0] u;
                    u = (m == 0) ? 5'h1A : (m == 1) ? 5'h1C : 5'h1E;
                    apply(u, 3'(pk), 32'hC3A5_1E69, 32'(amt));
                    check(res, ref_alu(u, 3'(pk), 32'hC3A5_1E69, 32'(amt)),
                          req_of(u, 3'(pk)), "shift amount sweep");
                end
            end
        end

        // All micro-ops against the model, all pack codes, random operands
        for (int i = 0; i < 12; i++) begin
            for (int pk = 0; pk < 8; pk++) begin
                for (int n = 0; n < 40; n++) begin
                    logic [31:0] a, b;
                    a = $urandom;
                    b = $urandom;
                    if (n == 0) a = 32'h0;
                    if (n == 1) b = 32'hFFFFFFFF;
                    if (n == 2) begin a = 32'h80000000; b = 32'h7FFFFFFF; end
                    apply(UOPS[i], 3'(pk), a, b);
                    check(res, ref_alu(UOPS[i], 3'(pk), a, b), req_of(UOPS[i], 3'(pk)),
                          "model compare");
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule